// File: doc/BRIEF.md
# Prescaled Master Clock Divider

This block derives a master clock enable from one of four candidate source clocks. Each source is presented as a stream of one-cycle enable pulses in the reference clock domain. A single control register picks the source and sets two division stages. The first stage is a 3-bit prescaler. Its codes 0 to 6 divide by a power of two, and code 7 divides by 3 or by 128, chosen at build time. The second stage divides further by a value looked up in a small parameter table.

Every change to the register restarts both division stages from zero and drops a ready flag. The flag rises again once the new setting has produced two complete output periods, so software can poll it after reprogramming. A build-time parameter places the prescaler field at bit 2 or at bit 4. The set of writable bits follows from that choice, and every other bit reads as zero.

Top module: `mck_divider`

## Requirements
- R1: After reset, rd_data is 0, ready is 0 and mck_tick is 0. The reset configuration is source 0, prescaler code 0 and divider field 0, which gives a total division of 1.
- R2: Register bits 1:0 select which src_tick bit is counted. Pulses on the other source bits have no effect on mck_tick.
- R3: Prescaler codes 0 to 6 divide the selected source pulses by 2 to the power of the code.
- R4: Prescaler code 7 divides by 3 when DIV3_EN is 1 and by 128 when DIV3_EN is 0.
- R5: The divider field at bits 9:8 selects an entry of DIV_TABLE. The default entries for codes 0, 1, 2 and 3 are 1, 2, 4 and 3. This divisor is applied after the prescaler, so the total division is the prescaler ratio times the table entry.
- R6: The prescaler field occupies bits PRES_LSB+2:PRES_LSB. The writable mask is 0x031F for PRES_LSB=2 and 0x0373 for PRES_LSB=4.
- R7: Bits outside the writable mask read as 0 and ignore writes. rd_data changes only on a write.
- R8: A write that changes any field clears both division stages. A source pulse in the write cycle is discarded, and ready reads 0 from the next cycle.
- R9: After reset or after a changing write, ready rises in the same cycle as the second mck_tick pulse.
- R10: A write whose masked value equals the stored value leaves ready unchanged and keeps the division phase. A source pulse in that cycle is still counted.
- R11: mck_tick is a one-cycle pulse. It is high in the cycle after the reference edge that captures the N-th counted source pulse, where N is the total division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NSRC | Enable pulses of the candidate source clocks |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write value |
| rd_data | output | REG_W | Register read-back value |
| mck_tick | output | 1 | Enable pulse of the divided master clock |
| ready | output | 1 | High when the master clock is stable |

## Verification
On every cycle, the assertions check the following. Both counters stay inside the range set by the current configuration, and every output pulse follows a counted source pulse. Ready falls after a changing write, never falls without one, and rises only together with an output pulse. Read-back holds steady between writes and shows no bits outside the mask.

Only the bench scenarios can show that the division ratios are correct. They also confirm that unselected sources are ignored and that code 7 gives divide-by-3 in one build and divide-by-128 in the other. Finally, they check the exact cycles of the output pulses, including the pulse that is discarded or kept in a write cycle.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int SEL_W    = 2;
  localparam int PRES_W   = 3;
  localparam int DSEL_W   = 2;
  localparam int DSEL_LSB = 8;
  localparam int RATIO_W  = 8;
  localparam int TAB_W    = 4;

  // Prescaler ratio for a code; code 7 is the special case.
  function automatic logic [RATIO_W-1:0] pres_ratio(input logic [PRES_W-1:0] code,
                                                    input bit div3);
    if (code == 3'd7) return div3 ? RATIO_W'(3) : RATIO_W'(128);
    return RATIO_W'(1) << code;
  endfunction

  // Writable bits: source select, prescaler at its position, divider field.
  function automatic logic [31:0] wr_mask(input int pres_lsb);
    return 32'h3 | (32'h7 << pres_lsb) | (32'h3 << DSEL_LSB);
  endfunction

  // Divisor table lookup; a zero entry is treated as 1.
  function automatic logic [TAB_W-1:0] tab_entry(input logic [4*TAB_W-1:0] tab,
                                                 input logic [DSEL_W-1:0] idx);
    logic [TAB_W-1:0] e;
    e = tab[idx*TAB_W +: TAB_W];
    return (e == '0) ? TAB_W'(1) : e;
  endfunction
endpackage

// File: rtl/mcd_cfg_reg.sv
module mcd_cfg_reg
  import mcd_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int PRES_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  cfg_q,
  output logic [SEL_W-1:0]  sel,
  output logic [PRES_W-1:0] pres,
  output logic [DSEL_W-1:0] dsel,
  output logic              cfg_change
);
  localparam logic [REG_W-1:0] MASK = REG_W'(wr_mask(PRES_LSB));

  logic [REG_W-1:0] wr_masked;

  assign wr_masked  = wr_data & MASK;
  assign cfg_change = wr_en && (wr_masked != cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= '0;
    else if (cfg_change) cfg_q <= wr_masked;
  end

  assign sel  = cfg_q[SEL_W-1:0];
  assign pres = cfg_q[PRES_LSB +: PRES_W];
  assign dsel = cfg_q[DSEL_LSB +: DSEL_W];

  p_no_stray_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & ~MASK) == '0);
  p_hold_without_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/mcd_prescaler.sv
module mcd_prescaler
  import mcd_pkg::*;
#(
  parameter int NSRC    = 4,
  parameter bit DIV3_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [NSRC-1:0]   src_tick,
  input  logic [SEL_W-1:0]  sel,
  input  logic [PRES_W-1:0] pres,
  output logic              src_hit,
  output logic              pre_done
);
  localparam int CNT_W = RATIO_W - 1;

  logic [(1<<SEL_W)-1:0] src_pad;
  logic [RATIO_W-1:0]    ratio;
  logic [CNT_W-1:0]      pre_cnt;
  logic                  at_last;

  assign src_pad  = (1 << SEL_W)'(src_tick);
  assign ratio    = pres_ratio(pres, DIV3_EN);
  assign src_hit  = src_pad[sel] && !clear;
  assign at_last  = ({1'b0, pre_cnt} == ratio - RATIO_W'(1));
  assign pre_done = src_hit && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_cnt <= '0;
    else if (clear)    pre_cnt <= '0;
    else if (pre_done) pre_cnt <= '0;
    else if (src_hit)  pre_cnt <= pre_cnt + CNT_W'(1);
  end

  p_pre_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pre_cnt} < ratio);
  p_clear_zeroes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> pre_cnt == '0);
endmodule

// File: rtl/mcd_postdiv.sv
module mcd_postdiv
  import mcd_pkg::*;
#(
  parameter logic [4*TAB_W-1:0] DIV_TABLE = 16'h3421
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              pre_done,
  input  logic [DSEL_W-1:0] dsel,
  output logic              out_pulse
);
  logic [TAB_W-1:0] dval;
  logic [TAB_W-1:0] div_cnt;

  assign dval      = tab_entry(DIV_TABLE, dsel);
  assign out_pulse = pre_done && (div_cnt == dval - TAB_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_cnt <= '0;
    else if (clear)     div_cnt <= '0;
    else if (out_pulse) div_cnt <= '0;
    else if (pre_done)  div_cnt <= div_cnt + TAB_W'(1);
  end

  p_post_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt < dval);
  p_post_needs_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_done && !clear |=> $stable(div_cnt));
endmodule

// File: rtl/mcd_ready.sv
module mcd_ready (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic out_pulse,
  output logic ready
);
  logic seen_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready    <= 1'b0;
      seen_one <= 1'b0;
    end else if (clear) begin
      ready    <= 1'b0;
      seen_one <= 1'b0;
    end else if (out_pulse && !ready) begin
      if (seen_one) ready <= 1'b1;
      seen_one <= ~seen_one;
    end
  end

  p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !ready);
  p_ready_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !clear |=> ready);
endmodule

// File: rtl/mck_divider.sv
module mck_divider
  import mcd_pkg::*;
#(
  parameter int                 NSRC      = 4,
  parameter int                 REG_W     = 16,
  parameter int                 PRES_LSB  = 2,
  parameter bit                 DIV3_EN   = 1'b1,
  parameter logic [4*TAB_W-1:0] DIV_TABLE = 16'h3421
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             mck_tick,
  output logic             ready
);
  logic [REG_W-1:0]  cfg_q;
  logic [SEL_W-1:0]  sel;
  logic [PRES_W-1:0] pres;
  logic [DSEL_W-1:0] dsel;
  logic              cfg_change;
  logic              src_hit;
  logic              pre_done;
  logic              out_pulse;

  mcd_cfg_reg #(.REG_W(REG_W), .PRES_LSB(PRES_LSB)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_q(cfg_q), .sel(sel), .pres(pres), .dsel(dsel),
    .cfg_change(cfg_change));

  mcd_prescaler #(.NSRC(NSRC), .DIV3_EN(DIV3_EN)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(cfg_change), .src_tick(src_tick),
    .sel(sel), .pres(pres), .src_hit(src_hit), .pre_done(pre_done));

  mcd_postdiv #(.DIV_TABLE(DIV_TABLE)) u_post (
    .clk(clk), .rst_n(rst_n), .clear(cfg_change), .pre_done(pre_done),
    .dsel(dsel), .out_pulse(out_pulse));

  mcd_ready u_rdy (
    .clk(clk), .rst_n(rst_n), .clear(cfg_change), .out_pulse(out_pulse),
    .ready(ready));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mck_tick <= 1'b0;
    else        mck_tick <= out_pulse;
  end

  assign rd_data = cfg_q;

  p_tick_after_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mck_tick |-> $past(src_hit));
  p_ready_rise_with_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> mck_tick);
  p_no_tick_after_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> !mck_tick);
endmodule

// File: tb/sim_mck_divider.sv
`timescale 1ns/1ps
module sim_mck_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0, src_tick1 = '0;
  logic        wr_en = 1'b0, wr_en1 = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, rd1;
  logic        mck_tick, mck1, ready, rdy1;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int q[$];
  logic [15:0] m_cfg = '0;
  int m_cnt = 0, m_ord = 0, m_T = 1;
  bit m_rdy = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mck_divider u0 (.clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .mck_tick(mck_tick), .ready(ready));

  mck_divider #(.PRES_LSB(4), .DIV3_EN(1'b0)) u1 (.clk(clk), .rst_n(rst_n),
    .src_tick(src_tick1), .wr_en(wr_en1), .wr_data(wr_data), .rd_data(rd1),
    .mck_tick(mck1), .ready(rdy1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Total division restated from the requirements (layout with PRES_LSB=2).
  function automatic int total_div(input logic [15:0] c);
    int p, d;
    p = (c[4:2] == 3'd7) ? 3 : (1 << c[4:2]);
    case (c[9:8]) 2'd0: d = 1; 2'd1: d = 2; 2'd2: d = 4; default: d = 3; endcase
    return p * d;
  endfunction

  // Model one counted selected pulse captured at the next edge.
  task automatic count_one();
    m_cnt++;
    if (m_cnt == m_T) begin
      m_cnt = 0;
      m_ord++;
      if (m_ord >= 2) m_rdy = 1;
      q.push_back((cyc + 1) * 2 + int'(m_rdy));
    end
  endtask

  task automatic tick(input bit noise);
    logic [3:0] s;
    s = 4'b1 << m_cfg[1:0];
    src_tick = noise ? 4'hF : s;
    count_one();
    @(negedge clk);
    src_tick = '0;
  endtask

  task automatic idle(input int n, input bit noise);
    for (int i = 0; i < n; i++) begin
      src_tick = noise ? ~(4'b1 << m_cfg[1:0]) : 4'b0;
      @(negedge clk);
    end
    src_tick = '0;
  endtask

  task automatic wr0(input logic [15:0] d, input bit tk);
    logic [15:0] nm;
    nm = d & 16'h031F;
    wr_en = 1'b1; wr_data = d;
    src_tick = tk ? (4'b1 << m_cfg[1:0]) : 4'b0;
    if (nm != m_cfg) begin
      m_cfg = nm; m_T = total_div(nm); m_cnt = 0; m_ord = 0; m_rdy = 0;
    end else if (tk) count_one();
    @(negedge clk);
    wr_en = 1'b0; src_tick = '0;
    chk(rd_data == m_cfg, "R7 readback", rd_data, m_cfg);
    chk(ready == m_rdy, "R8/R10 ready after write", ready, m_rdy);
  endtask

  task automatic run(input logic [15:0] d, input int n, input int gap, input bit noise);
    wr0(d, 1'b0);
    for (int i = 0; i < n; i++) begin
      tick(noise);
      if (gap > 0) idle(gap, noise);
    end
    idle(3, 1'b0);
    chk(q.size() == 0, "R11 pending ticks", q.size(), 0);
  endtask

  // Scoreboard monitor: pops expected pulse cycles and ready values.
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && (q[0] >> 1) < cyc) begin
        chk(1'b0, "R11 missed mck_tick", cyc, q[0] >> 1);
        void'(q.pop_front());
      end
      if (mck_tick) begin
        if (q.size() == 0) chk(1'b0, "R11/R2 extra mck_tick", cyc, -1);
        else begin
          int v;
          v = q.pop_front();
          chk(cyc == (v >> 1), "R3/R5/R11 tick cycle", cyc, v >> 1);
          chk(int'(ready) == (v & 1), "R9 ready at tick", ready, v & 1);
        end
      end
    end
  end

  initial begin
    int c1;
    repeat (3) @(negedge clk);
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);
    chk(ready == 0, "R1 ready", ready, 0);
    chk(mck_tick == 0, "R1 mck_tick", mck_tick, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 0 && mck_tick == 0, "R1 after release", ready, 0);
    // R1: reset config divides by 1
    for (int i = 0; i < 3; i++) tick(1'b0);
    idle(2, 1'b0);
    chk(ready == 1, "R9 ready after reset", ready, 1);
    // R6, R7: mask of both layouts
    wr0(16'hFFFF, 1'b0);
    wr_en1 = 1'b1; @(negedge clk); wr_en1 = 1'b0;
    chk(rd1 == 16'h0373, "R6 layout B mask", rd1, 16'h0373);
    // R3, R5, R2: sel2, code3 (/8), table 1 (/2) with noise
    run(16'h010E, 40, 1, 1'b1);
    // R4: sel1, code7 (/3), table 3 (/3)
    run(16'h031D, 27, 0, 1'b0);
    // R3: sel3, code6 (/64), table 2 (/4)
    run(16'h021B, 512, 0, 1'b0);
    // R10: identical write keeps phase and ready, upper bits ignored (R7)
    wr0(16'h0004, 1'b0);
    for (int i = 0; i < 6; i++) tick(1'b0);
    wr0(16'hF004, 1'b1);
    tick(1'b0);
    idle(2, 1'b0);
    chk(ready == 1, "R10 ready kept", ready, 1);
    // R8: changing write discards the pulse in its cycle
    wr0(16'h0000, 1'b1);
    tick(1'b0);
    tick(1'b0);
    idle(3, 1'b0);
    chk(q.size() == 0, "R8 pending ticks", q.size(), 0);
    // R4, R6: layout B, code 7 at bits 6:4 divides by 128
    wr_data = 16'h0070; wr_en1 = 1'b1; @(negedge clk); wr_en1 = 1'b0;
    c1 = 0;
    for (int i = 0; i < 256; i++) begin
      src_tick1 = 4'h1;
      @(negedge clk);
      src_tick1 = '0;
      if (mck1) c1++;
      if (i == 126) chk(c1 == 0, "R4 no tick before 128", c1, 0);
      if (i == 127) chk(c1 == 1, "R4 divide by 128", c1, 1);
    end
    chk(c1 == 2, "R4 two ticks in 256", c1, 2);
    chk(rdy1 == 1, "R9 layout B ready", rdy1, 1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule